// File: doc/BRIEF.md
# Serial Control Target with Register File and RAM Loader

This block is a slave-only two-wire serial bus target that lets a host controller set up a bank of 8-bit control registers and stream a write-strategy table into an on-chip RAM. The host sends a 7-bit device address first. Six bits of that address are fixed and the seventh comes from an address-select pin, so two of these blocks can share one bus. The host then sends a register pointer, followed by data bytes for a write or a repeated START and the read address for a read.

Burst writes to ordinary registers step the pointer by one per byte. One pointer value is a RAM port. Bytes written through it leave the pointer where it is and go out on a RAM write port at consecutive RAM locations, starting from location 0 for each burst. A burst read returns the same register for every byte. Event inputs set sticky status bits. An enable register gates these bits onto an active-low interrupt line, and reading the status register clears them. SCL and SDA are resynchronised to the system clock, which must run at eight or more times the SCL rate. The target never drives SCL. It only pulls SDA low through `sda_oe`.

Top module: `ctl_i2c_target`

## Requirements
- R1: The target acknowledges the device byte 0xDC (write) and 0xDD (read) when `addr_sel` is 0, and 0xDE (write) and 0xDF (read) when `addr_sel` is 1. Every other device byte gets no acknowledge.
- R2: After a device byte that does not match, the target ignores all traffic, repeated STARTs included, until the next STOP.
- R3: The first byte after the write address sets the register pointer, and the next data byte lands in that register. Register n appears on `regs_o[8n+7:8n]`. Registers 0x00 to NREG-1 are read/write.
- R4: Further data bytes in the same write go to the pointer plus one, plus two and so on. Each byte is acknowledged.
- R5: When the pointer equals the RAM port 0x42, data bytes come out as one-cycle `ram_we` pulses with `ram_addr` = 0, 1, 2 and so on. The pointer stays put, and a new pointer byte restarts the RAM index at 0.
- R6: A repeated START moves the target back to the device-byte stage. A read then returns the register that the pointer names, and every byte of the read repeats that same register.
- R7: Each bit of `evt_in` sets a sticky status bit, readable at 0x40. The read/write enable register sits at 0x41. `irq_n` goes low in the cycle after an enabled event, and masked events leave it high.
- R8: Reading the status register returns the sticky bits and clears them as the byte is loaded. A second byte in the same read returns 0x00, and `irq_n` is released.
- R9: Pointer values that map to nothing (NREG to 0x3F and above 0x42) read as 0x00 and ignore writes, and so does the RAM port on read. A burst that runs past the last register does not wrap around.
- R10: `sda_oe` rises only while SCL is low. It is 0 after every STOP and at all times while traffic is being ignored.
- R11: After reset `irq_n` is 1, `sda_oe` and `ram_we` are 0, and all registers are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| addr_sel | input | 1 | Selects the low device-address bit |
| evt_in | input | 8 | Interrupt event pulses, one per status bit |
| irq_n | output | 1 | Active-low interrupt request (open-drain level) |
| regs_o | output | NREG*8 | Contents of the control registers |
| ram_we | output | 1 | One-cycle RAM write strobe |
| ram_addr | output | RAM_AW | RAM location for the strobe |
| ram_wdata | output | 8 | RAM data for the strobe |

## Verification
The bench sweeps every 7-bit device address with both select values, and every register with single writes and with three-byte repeated reads. A decoder that compares the wrong bit would acknowledge a neighbour's address, and a read path that steps the pointer would return the next register on the second byte. Further tests cover a burst that runs off the end of the register bank, two RAM bursts in a row to check that the index restarts, and a repeated START after a rejected address. A target that wrapped the pointer, kept the old RAM index, or re-armed on any START would corrupt registers or acknowledge bytes it should ignore. The status test reads status twice in one burst, with one masked and one enabled event. A target that cleared status at the wrong moment, or ignored the mask, would show a wrong second byte or a wrong `irq_n` level.

// File: rtl/ctl_i2c_target.sv
module ctl_i2c_target #(
  parameter int NREG = 16,
  parameter int RAM_AW = 6,
  parameter logic [7:0] STAT_A = 8'h40,
  parameter logic [7:0] IEN_A = 8'h41,
  parameter logic [7:0] RAMP_A = 8'h42,
  parameter logic [5:0] DEV_HI = 6'b110111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic              addr_sel,
  input  logic [7:0]        evt_in,
  output logic              irq_n,
  output logic [NREG*8-1:0] regs_o,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata
);
  localparam int PW = $clog2(NREG);
  localparam logic [8:0] NREG9 = 9'(NREG);
  localparam logic [RAM_AW-1:0] IDX_ONE = RAM_AW'(1);

  typedef enum logic [2:0] {P_IDLE, P_SKIP, P_DEV, P_REG, P_WR, P_RD} phase_t;

  phase_t phase;
  logic [2:0] scl_p, sda_p;
  logic [3:0] cnt;
  logic [7:0] sh, ptr, ien, stat, rdata;
  logic [RAM_AW-1:0] ridx;
  logic [7:0] regs [NREG];

  wire scl_s = scl_p[1];
  wire sda_s = sda_p[1];
  wire scl_rise = scl_s & ~scl_p[2];
  wire scl_fall = ~scl_s & scl_p[2];
  wire bus_start = scl_s & scl_p[2] & sda_p[2] & ~sda_s;
  wire bus_stop = scl_s & scl_p[2] & ~sda_p[2] & sda_s;
  wire in_file = {1'b0, ptr} < NREG9;
  wire [PW-1:0] idx = ptr[PW-1:0];
  wire load_rd = (phase == P_RD) && scl_fall && (cnt == 4'd9);

  assign irq_n = ~|(stat & ien);

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_out
      assign regs_o[g*8 +: 8] = regs[g];
    end
  endgenerate

  always_comb begin
    rdata = 8'h00;
    if (ptr == STAT_A) rdata = stat;
    else if (ptr == IEN_A) rdata = ien;
    else if (in_file) rdata = regs[idx];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
      stat <= 8'h00;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
      stat <= ((load_rd && ptr == STAT_A) ? 8'h00 : stat) | evt_in;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= P_IDLE;
      cnt <= 4'd0;
      sh <= 8'h00;
      ptr <= 8'h00;
      ien <= 8'h00;
      ridx <= '0;
      sda_oe <= 1'b0;
      ram_we <= 1'b0;
      ram_addr <= '0;
      ram_wdata <= 8'h00;
      for (int i = 0; i < NREG; i++) regs[i] <= 8'h00;
    end else begin
      ram_we <= 1'b0;
      if (bus_start && phase != P_SKIP) begin
        phase <= P_DEV;
        cnt <= 4'd0;
        sda_oe <= 1'b0;
      end else if (bus_stop) begin
        phase <= P_IDLE;
        sda_oe <= 1'b0;
      end else if (phase == P_DEV || phase == P_REG || phase == P_WR) begin
        if (scl_rise && cnt < 4'd8) begin
          sh <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end else if (scl_fall && cnt == 4'd8) begin
          cnt <= 4'd9;
          sda_oe <= 1'b1;
          case (phase)
            P_DEV:
              if (sh[7:1] == {DEV_HI, addr_sel}) phase <= sh[0] ? P_RD : P_REG;
              else begin
                phase <= P_SKIP;
                sda_oe <= 1'b0;
              end
            P_REG: begin
              ptr <= sh;
              ridx <= '0;
              phase <= P_WR;
            end
            default:
              if (ptr == RAMP_A) begin
                ram_we <= 1'b1;
                ram_addr <= ridx;
                ram_wdata <= sh;
                ridx <= ridx + IDX_ONE;
              end else begin
                if (in_file) regs[idx] <= sh;
                if (ptr == IEN_A) ien <= sh;
                ptr <= ptr + 8'd1;
              end
          endcase
        end else if (scl_fall && cnt == 4'd9) begin
          sda_oe <= 1'b0;
          cnt <= 4'd0;
        end
      end else if (phase == P_RD) begin
        if (load_rd) begin
          sh <= rdata;
          sda_oe <= ~rdata[7];
          cnt <= 4'd0;
        end else if (scl_rise && cnt < 4'd8) cnt <= cnt + 4'd1;
        else if (scl_rise && cnt == 4'd8) begin
          if (sda_s) phase <= P_IDLE;
          else cnt <= 4'd9;
        end else if (scl_fall && cnt == 4'd8) sda_oe <= 1'b0;
        else if (scl_fall && cnt != 4'd0) begin
          sh <= {sh[6:0], 1'b0};
          sda_oe <= ~sh[6];
        end
      end
    end
endmodule

// File: rtl/ctl_i2c_target_chk.sv
module ctl_i2c_target_chk #(
  parameter int RW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          skipping,
  input logic [7:0]    evt_in,
  input logic [7:0]    ien,
  input logic          irq_n,
  input logic          ram_we,
  input logic [RW-1:0] regs_o
);
  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skipping |-> !sda_oe);

  // R10
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R7
  irq_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_in & ien)) |=> (!irq_n || !$stable(ien)));

  // R5
  ram_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $rose(sda_oe));

  // R4
  reg_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> $rose(sda_oe));
endmodule

bind ctl_i2c_target ctl_i2c_target_chk #(.RW(NREG*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .skipping(phase == P_SKIP), .evt_in(evt_in), .ien(ien), .irq_n(irq_n),
  .ram_we(ram_we), .regs_o(regs_o));

// File: tb/test_ctl_i2c_target.sv
`timescale 1ns/1ps
module test_ctl_i2c_target;
  localparam int NREG = 16;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_bus;
  logic sda_oe, addr_sel, irq_n, ram_we;
  logic [7:0] evt_in;
  logic [NREG*8-1:0] regs_o;
  logic [5:0] ram_addr;
  logic [7:0] ram_wdata;

  int nchk = 0, nerr = 0, nram = 0;
  logic [7:0] mreg [NREG];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  logic [5:0] ram_a [32];
  logic [7:0] ram_d [32];

  always #2.5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  ctl_i2c_target i_ctl_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .evt_in(evt_in), .irq_n(irq_n), .regs_o(regs_o),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata));

  always @(negedge clk)
    if (ram_we && nram < 32) begin
      ram_a[nram] = ram_addr;
      ram_d[nram] = ram_wdata;
      nram++;
    end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b1; w(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(Q); m_scl = 1'b1; w(2*Q); m_scl = 1'b0; w(Q);
    end
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q); ack = ~sda_bus; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); m_scl = 1'b1; w(Q); b[i] = sda_bus; w(Q); m_scl = 1'b0; w(Q);
    end
    m_sda = ~mack; w(Q); m_scl = 1'b1; w(2*Q); m_scl = 1'b0; w(Q); m_sda = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {6'b110111, addr_sel, rd};
  endfunction

  task automatic wr_burst(input logic [7:0] ra, input int n, output int acks);
    logic a;
    acks = 0;
    i2c_start;
    send_byte(dev(1'b0), a); acks += int'(a);
    send_byte(ra, a); acks += int'(a);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); acks += int'(a);
    end
    i2c_stop;
  endtask

  task automatic rd_burst(input logic [7:0] ra, input int n);
    logic a;
    i2c_start;
    send_byte(dev(1'b0), a);
    send_byte(ra, a);
    i2c_start;
    send_byte(dev(1'b1), a);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i < n - 1);
    i2c_stop;
  endtask

  task automatic regs_match(input string tag);
    for (int i = 0; i < NREG; i++)
      chk(regs_o[i*8 +: 8] == mreg[i], tag, regs_o[i*8 +: 8], mreg[i]);
  endtask

  task automatic pulse(input logic [7:0] e);
    evt_in = e; w(1); evt_in = 8'h00; w(2);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    logic a;
    int acks;
    addr_sel = 1'b0;
    evt_in = 8'h00;
    for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
    w(5);
    rst_n = 1'b1;
    w(4);

    // R11 reset state
    chk(irq_n == 1'b1, "R11 irq_n", irq_n, 1);
    chk(sda_oe == 1'b0, "R11 sda_oe", sda_oe, 0);
    chk(ram_we == 1'b0, "R11 ram_we", ram_we, 0);
    regs_match("R11 regs");

    // R1 full device-address sweep, both select values
    for (int s = 0; s < 2; s++) begin
      addr_sel = s[0];
      for (int ad = 0; ad < 128; ad++) begin
        i2c_start;
        send_byte({ad[6:0], 1'b0}, a);
        i2c_stop;
        chk(a == (ad == (s == 0 ? 8'h6E : 8'h6F)), "R1 address ack", a, ad == (s == 0 ? 8'h6E : 8'h6F));
        chk(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
      end
    end
    addr_sel = 1'b0;
    i2c_start; send_byte(8'hDD, a); chk(a, "R1 read 0xDD sel0", a, 1);
    recv_byte(rbuf[0], 1'b0); i2c_stop;
    addr_sel = 1'b1;
    i2c_start; send_byte(8'hDF, a); chk(a, "R1 read 0xDF sel1", a, 1);
    recv_byte(rbuf[0], 1'b0); i2c_stop;
    i2c_start; send_byte(8'hDD, a); chk(!a, "R1 read 0xDD sel1 nack", a, 0); i2c_stop;
    addr_sel = 1'b0;

    // R3 single write into every register
    for (int n = 0; n < NREG; n++) begin
      wbuf[0] = 8'((n * 37 + 5) & 8'hFF);
      mreg[n] = wbuf[0];
      wr_burst(8'(n), 1, acks);
      chk(acks == 3, "R3 write acks", acks, 3);
      chk(regs_o[n*8 +: 8] == mreg[n], "R3 write lands", regs_o[n*8 +: 8], mreg[n]);
    end
    regs_match("R3 all regs");

    // R6 repeated read returns the same register
    for (int n = 0; n < NREG; n++) begin
      rd_burst(8'(n), 3);
      for (int k = 0; k < 3; k++)
        chk(rbuf[k] == mreg[n], "R6 repeated read", rbuf[k], mreg[n]);
    end

    // R4 incremental write burst
    for (int i = 0; i < 5; i++) begin
      wbuf[i] = 8'(8'hA0 + i);
      mreg[3 + i] = wbuf[i];
    end
    wr_burst(8'h03, 5, acks);
    chk(acks == 7, "R4 burst acks", acks, 7);
    regs_match("R4 burst");

    // R9 unmapped pointers, no wrap
    wbuf[0] = 8'h55; wbuf[1] = 8'h66;
    mreg[15] = 8'h55;
    wr_burst(8'h0F, 2, acks);
    regs_match("R9 no wrap");
    wbuf[0] = 8'h77;
    wr_burst(8'h30, 1, acks);
    regs_match("R9 unmapped write");
    rd_burst(8'h30, 1);
    chk(rbuf[0] == 8'h00, "R9 unmapped read", rbuf[0], 0);
    rd_burst(8'h42, 1);
    chk(rbuf[0] == 8'h00, "R9 ram port read", rbuf[0], 0);

    // R5 RAM port bursts
    nram = 0;
    for (int i = 0; i < 10; i++) wbuf[i] = 8'((i * 11 + 3) & 8'hFF);
    wr_burst(8'h42, 10, acks);
    chk(acks == 12, "R5 ram acks", acks, 12);
    chk(nram == 10, "R5 ram strobes", nram, 10);
    for (int i = 0; i < 10; i++) begin
      chk(ram_a[i] == 6'(i), "R5 ram addr", ram_a[i], i);
      chk(ram_d[i] == wbuf[i], "R5 ram data", ram_d[i], wbuf[i]);
    end
    nram = 0;
    for (int i = 0; i < 3; i++) wbuf[i] = 8'(8'hF0 + i);
    wr_burst(8'h42, 3, acks);
    chk(nram == 3, "R5 second burst strobes", nram, 3);
    for (int i = 0; i < 3; i++) begin
      chk(ram_a[i] == 6'(i), "R5 index restart", ram_a[i], i);
      chk(ram_d[i] == wbuf[i], "R5 second data", ram_d[i], wbuf[i]);
    end
    regs_match("R5 regs untouched");

    // R2 ignore until stop, even across repeated start
    i2c_start;
    send_byte(8'hDE, a); chk(!a, "R2 wrong address nack", a, 0);
    i2c_start;
    send_byte(8'hDC, a); chk(!a, "R2 restart still ignored", a, 0);
    send_byte(8'h02, a); chk(!a, "R2 pointer ignored", a, 0);
    send_byte(8'h99, a); chk(!a, "R2 data ignored", a, 0);
    i2c_stop;
    chk(sda_oe == 1'b0, "R10 idle after stop", sda_oe, 0);
    regs_match("R2 regs untouched");
    rd_burst(8'h02, 1);
    chk(rbuf[0] == mreg[2], "R2 recovers after stop", rbuf[0], mreg[2]);

    // R7 / R8 interrupt path
    wbuf[0] = 8'h05;
    wr_burst(8'h41, 1, acks);
    rd_burst(8'h41, 1);
    chk(rbuf[0] == 8'h05, "R7 enable readback", rbuf[0], 5);
    chk(irq_n == 1'b1, "R7 idle irq", irq_n, 1);
    pulse(8'h02);
    chk(irq_n == 1'b1, "R7 masked event", irq_n, 1);
    pulse(8'h04);
    chk(irq_n == 1'b0, "R7 enabled event", irq_n, 0);
    rd_burst(8'h40, 2);
    chk(rbuf[0] == 8'h06, "R8 status value", rbuf[0], 6);
    chk(rbuf[1] == 8'h00, "R8 cleared on read", rbuf[1], 0);
    chk(irq_n == 1'b1, "R8 irq released", irq_n, 1);
    rd_burst(8'h40, 1);
    chk(rbuf[0] == 8'h00, "R8 stays clear", rbuf[0], 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule